// File: doc/BRIEF.md
# CPU Interrupt Dispatch Controller

This block holds the interrupt control state for a small 8-bit processor core. Five request sources latch into a request register, and a 5-bit enable mask qualifies them. The block also holds the master interrupt enable and a short countdown that delays an enable instruction's effect. At each opcode-fetch boundary it decides whether the core diverts into an interrupt. It also wakes the core from its low-power wait states.

The core feeds the block one-cycle decoded strobes: fetch boundary, prefix-in-progress, enable, disable, return-with-enable, wait entry, deep-stop entry and lock-up. When the block takes an interrupt it drops the master enable at once. A fixed number of cycles later, standing in for the core's stack push, it picks the highest-priority enabled source at that moment. It clears that source's request bit and drives the source's vector for one cycle. If the request was withdrawn in the meantime, it drives a zero vector instead.

Top module: `irq_dispatch`

## Requirements
- R1: The request register `req_o` shows, one cycle later, the bits of `req_set_i` set and the bits of `req_clr_i` cleared. A set wins over a clear of the same bit. The bit being served (R3) is also cleared.
- R2: Among requests that are both pending and enabled, bit 0 has the highest priority and bit 4 the lowest. `src_o` gives the chosen bit index in the vector cycle.
- R3: `vec_valid_o` is high for exactly one cycle, three cycles after the cycle in which `take_o` is high. In that cycle `vec_o` = 0x0040 + 8 × `src_o`, and the served request bit clears at the following edge. Outside the vector cycle `vec_o` is 0 and `src_o` is 5.
- R4: If no enabled request remains in the vector cycle, `src_o` is 5, `vec_o` is 0 and no request bit is cleared.
- R5: `pend_o` is high exactly when some bit is set in both the request register and `en_mask_i`.
- R6: `ei_i` loads the delay counter with 2, but only when the counter is 0. A fetch with `prefix_i` low decrements a non-zero counter. When the counter steps from 1 to 0 the master enable `ime_o` sets, and that same fetch may already take an interrupt.
- R7: `di_i` clears the master enable and the counter. `reti_i` loads the counter with 1. In the same cycle the precedence is `di_i`, then `reti_i`, then `ei_i`, then the fetch decrement.
- R8: `take_o` is high at a fetch with `prefix_i` low only when all of these hold: an enabled request is pending, the master enable is in effect, the core is not locked, and no vector sequence is running. Taking an interrupt clears `ime_o`.
- R9: `halt_i` sets `halted_o`. While halted, any enabled request raises `halt_wake_o` for one cycle and clears `halted_o`, even with the master enable off. If `ime_o` is high and the core is not locked, `take_o` rises in that same cycle.
- R10: `stop_i` sets `stopped_o`. While stopped, request bit 4 raises `stop_wake_o` and clears `stopped_o` whatever the mask says, and no interrupt is taken by it.
- R11: `jam_i` sets `jammed_o`, which stays set until reset. While it is set, `take_o` stays low.
- R12: After reset, all outputs are low, except `src_o`, which is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | 5 | Request bits to raise |
| req_clr_i | input | 5 | Request bits to withdraw |
| en_mask_i | input | 5 | Per-source enable mask |
| fetch_i | input | 1 | Opcode-fetch boundary strobe |
| prefix_i | input | 1 | Fetch follows a prefix byte |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| reti_i | input | 1 | Return-with-enable strobe |
| halt_i | input | 1 | Wait-state entry strobe |
| stop_i | input | 1 | Deep-stop entry strobe |
| jam_i | input | 1 | Core lock-up strobe |
| take_o | output | 1 | Interrupt taken this cycle |
| vec_valid_o | output | 1 | Vector cycle strobe |
| vec_o | output | 16 | Vector address |
| src_o | output | 3 | Served source index, 5 for none |
| req_o | output | 5 | Request register |
| pend_o | output | 1 | Enabled request pending |
| ime_o | output | 1 | Master enable |
| halted_o | output | 1 | Core in wait state |
| stopped_o | output | 1 | Core in deep stop |
| jammed_o | output | 1 | Core locked up |
| halt_wake_o | output | 1 | Wait state ends this cycle |
| stop_wake_o | output | 1 | Deep stop ends this cycle |

## Verification
The assertions assume the core raises `fetch_i` only when it is neither halted nor stopped, as a real core would. The directed stimulus keeps to this: it issues fetches only while the core is running. In the random phase, the fetch strobe is held low whenever the bench's model says the core is halted or stopped. The random phase may still fire enable, disable and return strobes on a fetch cycle, so it covers the precedence rules of R7.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned IDX_W = $clog2(NSRC + 1);
  localparam int unsigned VEC_W = 16;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0040;
  localparam logic [VEC_W-1:0] VEC_STEP = 16'h0008;
endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned NSRC  = irq_pkg::NSRC,
  parameter int unsigned IDX_W = irq_pkg::IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  act_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NSRC-1:0]  hit_o
);
  logic [NSRC:0] lower;

  assign lower[0] = 1'b0;
  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    assign hit_o[i]     = act_i[i] & ~lower[i];
    assign lower[i+1]   = lower[i] | act_i[i];
  end

  assign found_o = lower[NSRC];

  always_comb begin
    idx_o = IDX_W'(NSRC);
    for (int i = 0; i < NSRC; i++)
      if (hit_o[i]) idx_o = IDX_W'(i);
  end

  // R2: at most one winner, and it is an active source with nothing active below it
  a_r2_onehot_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));
  a_r2_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (act_i[idx_o] && ((act_i & ((NSRC'(1) << idx_o) - NSRC'(1))) == '0)));
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl #(
  parameter int unsigned EI_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ei_i,
  input  logic di_i,
  input  logic reti_i,
  input  logic take_i,
  output logic ime_o,
  output logic ime_eff_o
);
  localparam int unsigned CNT_W = $clog2(EI_DLY + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ime_q, ime_d;

  // enable lands at the fetch that drains the counter
  assign ime_eff_o = ime_q | (tick_i & ~di_i & (cnt_q == CNT_W'(1)));
  assign ime_o     = ime_q;

  always_comb begin
    cnt_d = cnt_q;
    if (di_i)                            cnt_d = '0;
    else if (reti_i)                     cnt_d = CNT_W'(1);
    else if (ei_i && cnt_q == '0)        cnt_d = CNT_W'(EI_DLY);
    else if (tick_i && cnt_q != '0)      cnt_d = cnt_q - CNT_W'(1);
  end

  always_comb begin
    if (di_i || take_i) ime_d = 1'b0;
    else                ime_d = ime_eff_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ime_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ime_q <= ime_d;
    end
  end

  a_r7_di_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> (!ime_q && cnt_q == '0));
  a_r7_reti_loads_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !di_i) |=> (cnt_q == CNT_W'(1)));
  a_r6_ei_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !di_i && !reti_i && cnt_q != '0) |=> (cnt_q <= $past(cnt_q)));
  a_r6_set_only_on_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ime_q) |-> ($past(tick_i) && $past(cnt_q) == CNT_W'(1)));
endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq #(
  parameter int unsigned VEC_DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic busy_o,
  output logic fire_o
);
  localparam int unsigned DLY_W = (VEC_DLY > 1) ? $clog2(VEC_DLY) : 1;

  logic [DLY_W-1:0] dly_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign fire_o = busy_q && (dly_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dly_q  <= '0;
    end else if (take_i) begin
      busy_q <= 1'b1;
      dly_q  <= DLY_W'(VEC_DLY - 1);
    end else if (busy_q) begin
      if (dly_q == '0) busy_q <= 1'b0;
      else             dly_q  <= dly_q - DLY_W'(1);
    end
  end

  a_r3_single_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  a_r8_no_take_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !take_i);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int unsigned NSRC     = irq_pkg::NSRC,
  parameter int unsigned IDX_W    = irq_pkg::IDX_W,
  parameter int unsigned VEC_W    = irq_pkg::VEC_W,
  parameter logic [15:0] VEC_BASE = irq_pkg::VEC_BASE,
  parameter logic [15:0] VEC_STEP = irq_pkg::VEC_STEP,
  parameter int unsigned VEC_DLY  = 3,
  parameter int unsigned EI_DLY   = 2,
  parameter int unsigned STOP_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  req_set_i,
  input  logic [NSRC-1:0]  req_clr_i,
  input  logic [NSRC-1:0]  en_mask_i,
  input  logic             fetch_i,
  input  logic             prefix_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             reti_i,
  input  logic             halt_i,
  input  logic             stop_i,
  input  logic             jam_i,
  output logic             take_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [IDX_W-1:0] src_o,
  output logic [NSRC-1:0]  req_o,
  output logic             pend_o,
  output logic             ime_o,
  output logic             halted_o,
  output logic             stopped_o,
  output logic             jammed_o,
  output logic             halt_wake_o,
  output logic             stop_wake_o
);
  logic [NSRC-1:0] req_q, act, hit, svc_clr;
  logic            halted_q, stopped_q, jammed_q;
  logic            tick, ime_eff, busy, fire, found;
  logic [IDX_W-1:0] idx;

  assign act    = req_q & en_mask_i;
  assign pend_o = |act;
  assign tick   = fetch_i & ~prefix_i;

  irq_enable_ctrl #(.EI_DLY(EI_DLY)) u_en (
    .clk_i, .rst_ni, .tick_i(tick), .ei_i, .di_i, .reti_i,
    .take_i(take_o), .ime_o, .ime_eff_o(ime_eff)
  );

  irq_prio_sel #(.NSRC(NSRC), .IDX_W(IDX_W)) u_sel (
    .clk_i, .rst_ni, .act_i(act), .found_o(found), .idx_o(idx), .hit_o(hit)
  );

  irq_vec_seq #(.VEC_DLY(VEC_DLY)) u_seq (
    .clk_i, .rst_ni, .take_i(take_o), .busy_o(busy), .fire_o(fire)
  );

  // decision: fetch boundary, or wake from halt with enable already on
  assign take_o = ~busy & ~jammed_q & pend_o &
                  ((tick & ime_eff) | (halted_q & ime_o));

  assign halt_wake_o = halted_q & pend_o;
  assign stop_wake_o = stopped_q & req_q[STOP_SRC];

  assign vec_valid_o = fire;
  assign src_o       = fire ? idx : IDX_W'(NSRC);
  assign vec_o       = (fire && found) ? VEC_BASE + VEC_W'(idx) * VEC_STEP : '0;
  assign svc_clr     = fire ? hit : '0;

  assign req_o     = req_q;
  assign halted_o  = halted_q;
  assign stopped_o = stopped_q;
  assign jammed_o  = jammed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= '0;
      halted_q  <= 1'b0;
      stopped_q <= 1'b0;
      jammed_q  <= 1'b0;
    end else begin
      req_q <= (req_q & ~req_clr_i & ~svc_clr) | req_set_i;
      if (halt_i)           halted_q <= 1'b1;
      else if (halt_wake_o) halted_q <= 1'b0;
      if (stop_i)           stopped_q <= 1'b1;
      else if (stop_wake_o) stopped_q <= 1'b0;
      if (jam_i)            jammed_q <= 1'b1;
    end
  end

  a_r3_served_bit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && src_o < IDX_W'(NSRC) && !req_set_i[src_o]) |=> !req_q[$past(src_o)]);
  a_r4_none_zero_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && src_o == IDX_W'(NSRC)) |-> (vec_o == '0));
  a_r8_take_clears_ime: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !ime_o);
  a_r11_jam_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jammed_q |-> !take_o);
  a_r11_jam_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jammed_q |=> jammed_q);
  a_r9_wake_ends_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_wake_o && !halt_i) |=> !halted_q);
  a_r10_stop_no_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_wake_o && !halted_q && !fetch_i) |-> !take_o);
endmodule

// File: tb/irq_dispatch_tb_top.sv
module irq_dispatch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] req_set = '0, req_clr = '0, en_mask = '0;
  logic fetch = 0, prefix = 0, ei = 0, di = 0, reti = 0, halt = 0, stop = 0, jam = 0;
  logic take, vvalid, pend, ime, halted, stopped, jammed, hwake, swake;
  logic [15:0] vec;
  logic [2:0] src;
  logic [4:0] req;

  irq_dispatch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(req_set), .req_clr_i(req_clr),
    .en_mask_i(en_mask), .fetch_i(fetch), .prefix_i(prefix), .ei_i(ei), .di_i(di),
    .reti_i(reti), .halt_i(halt), .stop_i(stop), .jam_i(jam), .take_o(take),
    .vec_valid_o(vvalid), .vec_o(vec), .src_o(src), .req_o(req), .pend_o(pend),
    .ime_o(ime), .halted_o(halted), .stopped_o(stopped), .jammed_o(jammed),
    .halt_wake_o(hwake), .stop_wake_o(swake)
  );

  int checks = 0, errors = 0;
  bit chk_cancel = 0;

  // reference model state
  logic [4:0] m_req = '0;
  bit m_ime = 0, m_halt = 0, m_stop = 0, m_jam = 0, m_busy = 0;
  int m_cnt = 0, m_dly = 0;
  // model outputs for the current cycle
  bit e_pend, e_tick, e_ieff, e_take, e_valid, e_hw, e_sw;
  int e_src;
  logic [15:0] e_vec;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    e_pend  = (m_req & en_mask) != 0;
    e_tick  = fetch && !prefix;
    e_ieff  = m_ime || (e_tick && m_cnt == 1 && !di);
    e_take  = !m_busy && !m_jam && e_pend && ((e_tick && e_ieff) || (m_halt && m_ime));
    e_valid = m_busy && m_dly == 0;
    e_src   = 5;
    for (int i = 4; i >= 0; i--) if (m_req[i] && en_mask[i]) e_src = i;
    if (!e_valid) e_src = 5;
    e_vec   = (e_src < 5) ? 16'h0040 + 16'(8 * e_src) : 16'h0000;
    e_hw    = m_halt && e_pend;
    e_sw    = m_stop && m_req[4];
  endtask

  task automatic model_step();
    logic [4:0] served;
    served = (e_valid && e_src < 5) ? 5'(1 << e_src) : 5'b0;
    m_req  = (m_req & ~req_clr & ~served) | req_set;
    if (di) m_ime = 0; else if (e_take) m_ime = 0; else m_ime = e_ieff;
    if (di) m_cnt = 0;
    else if (reti) m_cnt = 1;
    else if (ei && m_cnt == 0) m_cnt = 2;
    else if (e_tick && m_cnt > 0) m_cnt--;
    if (e_take) begin m_busy = 1; m_dly = 2; end
    else if (m_busy) begin if (m_dly == 0) m_busy = 0; else m_dly--; end
    if (halt) m_halt = 1; else if (e_hw) m_halt = 0;
    if (stop) m_stop = 1; else if (e_sw) m_stop = 0;
    if (jam) m_jam = 1;
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
    model_eval();
    check("R8 take",       32'(take),   32'(e_take));
    check("R3 vec_valid",  32'(vvalid), 32'(e_valid));
    check("R3 vec",        32'(vec),    32'(e_vec));
    check("R2 src",        32'(src),    32'(e_src));
    check("R1 req",        32'(req),    32'(m_req));
    check("R5 pend",       32'(pend),   32'(e_pend));
    check("R6 ime",        32'(ime),    32'(m_ime));
    check("R9 halt_wake",  32'(hwake),  32'(e_hw));
    check("R9 halted",     32'(halted), 32'(m_halt));
    check("R10 stop_wake", 32'(swake),  32'(e_sw));
    check("R10 stopped",   32'(stopped),32'(m_stop));
    check("R11 jammed",    32'(jammed), 32'(m_jam));
    if (chk_cancel) begin
      check("R4 cancel valid", 32'(vvalid), 32'd1);
      check("R4 cancel src",   32'(src),    32'd5);
      check("R4 cancel vec",   32'(vec),    32'd0);
      chk_cancel = 0;
    end
    @(posedge clk);
    #1;
    model_step();
    req_set = '0; req_clr = '0;
    fetch = 0; prefix = 0; ei = 0; di = 0; reti = 0; halt = 0; stop = 0; jam = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12: reset state
    #1;
    check("R12 take", 32'(take), 0);
    check("R12 ime", 32'(ime), 0);
    check("R12 req", 32'(req), 0);
    check("R12 src", 32'(src), 5);
    check("R12 flags", 32'({halted, stopped, jammed, vvalid}), 0);
    idle(2);

    // R8: pending but master enable off
    en_mask = 5'h1F; req_set = 5'b01010; cyc();
    fetch = 1; cyc();
    // R6: enable after two unprefixed fetches, take on the second, vector src 1
    ei = 1; cyc();
    fetch = 1; cyc();
    fetch = 1; cyc();
    idle(4);
    // R7: return-with-enable, prefixed fetch does not tick
    reti = 1; cyc();
    fetch = 1; prefix = 1; cyc();
    fetch = 1; cyc();
    idle(4);

    // R4: request withdrawn between take and vector
    req_set = 5'b00100; ei = 1; cyc();
    fetch = 1; cyc();
    fetch = 1; cyc();
    req_clr = 5'b00100; cyc();
    cyc();
    chk_cancel = 1; cyc();
    idle(2);

    // R7: DI cancels pending enable
    ei = 1; cyc();
    di = 1; cyc();
    check("R7 ime after di", 32'(ime), 0);
    fetch = 1; cyc();
    fetch = 1; cyc();
    fetch = 1; cyc();

    // R9: halt wake with master enable off
    en_mask = 5'b0; req_set = 5'b00001; cyc();
    halt = 1; cyc();
    idle(3);
    en_mask = 5'h1F; cyc();
    idle(2);
    ei = 1; cyc();
    fetch = 1; cyc();
    fetch = 1; cyc();
    idle(4);
    // R9: halt wake with master enable on
    reti = 1; cyc();
    fetch = 1; cyc();
    halt = 1; cyc();
    cyc();
    req_set = 5'b00100; cyc();
    idle(5);

    // R10: stop wake by bit 4 regardless of mask
    en_mask = 5'b0; stop = 1; cyc();
    idle(2);
    req_set = 5'b10000; cyc();
    idle(2);
    req_clr = 5'h1F; cyc();

    // random phase, fetch held off while halted or stopped
    for (int k = 0; k < 400; k++) begin
      en_mask = 5'($urandom);
      req_set = (($urandom % 4) == 0) ? 5'($urandom) : 5'b0;
      req_clr = (($urandom % 5) == 0) ? 5'($urandom) : 5'b0;
      fetch   = (!m_halt && !m_stop) && (($urandom % 2) == 0);
      prefix  = fetch && (($urandom % 5) == 0);
      ei      = ($urandom % 6) == 0;
      di      = ($urandom % 15) == 0;
      reti    = ($urandom % 15) == 0;
      halt    = !m_halt && !m_stop && (($urandom % 25) == 0);
      stop    = !m_halt && !m_stop && !halt && (($urandom % 40) == 0);
      cyc();
      if (m_stop && (k % 7 == 0)) req_set = 5'b10000;
    end
    req_set = 5'b10000; en_mask = 5'h1F; cyc();
    idle(6);

    // R11: jam blocks interrupts
    ei = 1; cyc();
    fetch = 1; cyc();
    jam = 1; cyc();
    req_set = 5'b00010; cyc();
    reti = 1; cyc();
    fetch = 1; cyc();
    fetch = 1; cyc();
    check("R11 no take when jammed", 32'(take), 0);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule